// File: doc/BRIEF.md
# Frame-Aligned PRBS-10 Bit Error Checker

This block sits behind a clock-and-data recovery stage and judges the quality of the recovered bitstream. It watches the serial input for the single run of ten ones that a maximal-length 10-bit pseudo-random sequence produces once per 1023-bit period. That run marks a known phase of the sequence, so its detection reseeds a local reference generator which from then on produces the same bit as the one being received.

Each received bit is compared with the reference bit. Both pass through a retiming register, their XOR is registered again, and a set mismatch increments a 16-bit error counter that stops at its maximum value. A synchronous clear input returns the counter to zero. The count is also presented as four hexadecimal seven-segment digits with active-low segments.

Control is a two-state machine. State `ST_HUNT` (after reset) waits for the alignment event; the transition `hunt_to_track` fires on the registered ten-ones detection and moves to `ST_TRACK`, which is held until reset (transition `track_hold`). The lock flag is high in `ST_TRACK` only, and only bits that entered the compare pipeline while locked are counted.

Top module: `pn10_frame_checker`

## Requirements
- R1: While reset is asserted and after it is released with no input activity, `locked` is 0, `err_count` is 0 and all four digits show the code for zero (7'b1000000).
- R2: The reference generator implements x^10 + x^7 + 1: the next bit 0 is register bit 9 XOR register bit 6, the register shifts toward bit 9, the reference output is bit 9, and a reseed loads all ones, so the reference restarts with ten ones followed by a zero.
- R3: Ten consecutive ones on `ser_in` cause `locked` to rise; it is 0 after the first clock edge following the edge that samples the tenth one and 1 after the second. A stream with no run of ten ones never sets `locked`.
- R4: Bits received before lock are never counted: `err_count` stays 0 while `locked` is 0.
- R5: An error-free sequence that stays in step keeps `err_count` at 0 and `locked` at 1, including across later recurrences of the ten-ones run.
- R6: A single inverted bit raises `err_count` by exactly one; the new value appears 14 clock edges after the edge that samples the bad bit and not on the 13th.
- R7: The counter saturates: once at 16'hFFFF further mismatches leave it at 16'hFFFF.
- R8: `clr_cnt` high at a clock edge sets `err_count` to 0 at that edge, taking priority over an increment, and does not change `locked`.
- R9: Digit k shows count bits [4k+3:4k]; segment bits are ordered 6..0 = g,f,e,d,c,b,a, active low, with codes (hex) for values 0..F: 40,79,24,30,19,12,02,78,00,10,08,03,46,21,06,0E.
- R10: Over a stream carrying several isolated inverted bits, or a stretch forced to zero, the count equals exactly the number of received bits that differ from the sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_bit | input | 1 | Recovered bit clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 1 | Recovered serial data bit |
| clr_cnt | input | 1 | Synchronous clear of the error counter |
| locked | output | 1 | High once the reference has been aligned |
| err_count | output | 16 | Saturating count of mismatched bits |
| seg_d0 | output | 7 | Digit for count bits 3..0, active low |
| seg_d1 | output | 7 | Digit for count bits 7..4, active low |
| seg_d2 | output | 7 | Digit for count bits 11..8, active low |
| seg_d3 | output | 7 | Digit for count bits 15..12, active low |

## Verification
A received bit takes 14 clock edges from its sampling edge to a change of the count (eleven to leave the alignment window, one retime, one XOR register, one counter update), the lock flag follows the tenth one by two edges, and a clear takes effect on the edge that samples it. The bench drives each bit on a falling edge and records the outputs at that same falling edge, so the value seen while driving bit n+k reflects exactly k-1 rising edges after bit n was sampled. The latency checks pick the 13th and 14th observation after a bad bit, the lock check the first and second after the tenth one, and counts over longer stretches are read after a 20-bit flush so the pipeline is empty.

// File: rtl/pn10_chk_pkg.sv
package pn10_chk_pkg;

    // Tracking state of the alignment controller.
    typedef enum logic [0:0] {
        ST_HUNT  = 1'b0,
        ST_TRACK = 1'b1
    } trk_state_t;

    // Hex nibble to active-low segment pattern, bit order g f e d c b a.
    function automatic logic [6:0] hex_to_seg(input logic [3:0] nib);
        logic [6:0] pat;
        unique case (nib)
            4'h0: pat = 7'b1000000;
            4'h1: pat = 7'b1111001;
            4'h2: pat = 7'b0100100;
            4'h3: pat = 7'b0110000;
            4'h4: pat = 7'b0011001;
            4'h5: pat = 7'b0010010;
            4'h6: pat = 7'b0000010;
            4'h7: pat = 7'b1111000;
            4'h8: pat = 7'b0000000;
            4'h9: pat = 7'b0010000;
            4'hA: pat = 7'b0001000;
            4'hB: pat = 7'b0000011;
            4'hC: pat = 7'b1000110;
            4'hD: pat = 7'b0100001;
            4'hE: pat = 7'b0000110;
            4'hF: pat = 7'b0001110;
            default: pat = 7'b1111111;
        endcase
        return pat;
    endfunction

endpackage

// File: rtl/pn10_frame_detect.sv
// Receive window: finds the run of PN_LEN ones and delays the stream so
// that the bit leaving the window lines up with a freshly reseeded reference.
module pn10_frame_detect #(
    parameter int PN_LEN = 10,
    parameter int LAG    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_in,
    output logic align_hit,
    output logic rx_bit
);
    localparam int SR_W = PN_LEN + LAG;

    logic [SR_W-1:0] win_q;
    logic            run_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q <= '0;
        end else begin
            win_q <= {win_q[SR_W-2:0], ser_in};
        end
    end

    // Newest PN_LEN bits all ones marks the sequence start.
    always_comb begin
        run_seen = &win_q[PN_LEN-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            align_hit <= 1'b0;
        end else begin
            align_hit <= run_seen;
        end
    end

    assign rx_bit = win_q[SR_W-1];

endmodule

// File: rtl/pn10_ref_gen.sv
// Local reference sequence, reseeded to all ones by the alignment pulse.
module pn10_ref_gen #(
    parameter int PN_LEN = 10,
    parameter int TAP    = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic reseed,
    output logic ref_bit
);
    logic [PN_LEN-1:0] lfsr_q;
    logic              fb;

    always_comb begin
        fb = lfsr_q[PN_LEN-1] ^ lfsr_q[TAP-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lfsr_q <= '1;
        end else if (reseed) begin
            lfsr_q <= '1;
        end else begin
            lfsr_q <= {lfsr_q[PN_LEN-2:0], fb};
        end
    end

    assign ref_bit = lfsr_q[PN_LEN-1];

endmodule

// File: rtl/pn10_err_tally.sv
// Retime, compare, retime, then a saturating counter. A qualifier travels
// beside the data so only bits that entered while locked are counted.
module pn10_err_tally #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_bit,
    input  logic             ref_bit,
    input  logic             qual,
    input  logic             clr,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic rx_r, ref_r, qual_r;
    logic miss_r, qual_rr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_r    <= 1'b0;
            ref_r   <= 1'b0;
            qual_r  <= 1'b0;
            miss_r  <= 1'b0;
            qual_rr <= 1'b0;
        end else begin
            rx_r    <= rx_bit;
            ref_r   <= ref_bit;
            qual_r  <= qual;
            miss_r  <= rx_r ^ ref_r;
            qual_rr <= qual_r;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (qual_rr && miss_r && (count != CNT_MAX)) begin
            count <= count + CNT_W'(1);
        end
    end

endmodule

// File: rtl/pn10_hex_seg.sv
module pn10_hex_seg (
    input  logic [3:0] nib,
    output logic [6:0] seg
);
    import pn10_chk_pkg::*;

    always_comb begin
        seg = hex_to_seg(nib);
    end

endmodule

// File: rtl/pn10_frame_checker.sv
module pn10_frame_checker #(
    parameter int PN_LEN = 10,
    parameter int TAP    = 7
) (
    input  logic        clk_bit,
    input  logic        rst_n,
    input  logic        ser_in,
    input  logic        clr_cnt,
    output logic        locked,
    output logic [15:0] err_count,
    output logic [6:0]  seg_d0,
    output logic [6:0]  seg_d1,
    output logic [6:0]  seg_d2,
    output logic [6:0]  seg_d3
);
    import pn10_chk_pkg::*;

    localparam int CNT_W   = 16;
    localparam int NUM_DIG = CNT_W / 4;
    // Cycles between the tenth one and the reseeded reference output:
    // one for the registered detection, one for the reseed itself.
    localparam int LAG     = 2;

    trk_state_t state_q, state_d;
    logic       align_hit;
    logic       rx_bit;
    logic       ref_bit;
    logic [6:0] seg_all [NUM_DIG];

    // State register.
    always_ff @(posedge clk_bit or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: hunt_to_track on alignment, track_hold afterwards.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT:  if (align_hit) state_d = ST_TRACK;
            ST_TRACK: state_d = ST_TRACK;
            default:  state_d = ST_HUNT;
        endcase
    end

    // Outputs of the state machine.
    always_comb begin
        unique case (state_q)
            ST_TRACK: locked = 1'b1;
            default:  locked = 1'b0;
        endcase
    end

    pn10_frame_detect #(
        .PN_LEN (PN_LEN),
        .LAG    (LAG)
    ) u_detect (
        .clk       (clk_bit),
        .rst_n     (rst_n),
        .ser_in    (ser_in),
        .align_hit (align_hit),
        .rx_bit    (rx_bit)
    );

    pn10_ref_gen #(
        .PN_LEN (PN_LEN),
        .TAP    (TAP)
    ) u_ref (
        .clk     (clk_bit),
        .rst_n   (rst_n),
        .reseed  (align_hit),
        .ref_bit (ref_bit)
    );

    pn10_err_tally #(
        .CNT_W (CNT_W)
    ) u_tally (
        .clk     (clk_bit),
        .rst_n   (rst_n),
        .rx_bit  (rx_bit),
        .ref_bit (ref_bit),
        .qual    (locked),
        .clr     (clr_cnt),
        .count   (err_count)
    );

    for (genvar g = 0; g < NUM_DIG; g++) begin : g_digit
        pn10_hex_seg u_seg (
            .nib (err_count[4*g +: 4]),
            .seg (seg_all[g])
        );
    end

    assign seg_d0 = seg_all[0];
    assign seg_d1 = seg_all[1];
    assign seg_d2 = seg_all[2];
    assign seg_d3 = seg_all[3];

endmodule

// File: rtl/pn10_frame_checker_props.sv
module pn10_frame_checker_props (
    input logic        clk,
    input logic        rst_n,
    input logic        clr_cnt,
    input logic        locked,
    input logic [15:0] err_count,
    input logic [6:0]  seg0,
    input logic [6:0]  seg3
);
    // R3: lock is held once gained.
    p_lock_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);

    // R4: nothing is counted while unlocked.
    p_no_count_unlocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && !clr_cnt) |=> $stable(err_count));

    // R6: the count moves by at most one per bit.
    p_single_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_cnt |=> (err_count == $past(err_count)) ||
                     (err_count == $past(err_count) + 16'd1));

    // R7: saturation, no wrap.
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (err_count == 16'hFFFF && !clr_cnt) |=> err_count == 16'hFFFF);

    // R8: clear empties the counter and keeps lock.
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_cnt |=> (err_count == 16'd0) && (locked == $past(locked)));

    // R9: zero and full scale digits.
    p_seg_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_count == 16'd0) |-> (seg0 == 7'b1000000 && seg3 == 7'b1000000));
    p_seg_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_count == 16'hFFFF) |-> (seg0 == 7'b0001110 && seg3 == 7'b0001110));

endmodule

bind pn10_frame_checker pn10_frame_checker_props u_props (
    .clk       (clk_bit),
    .rst_n     (rst_n),
    .clr_cnt   (clr_cnt),
    .locked    (locked),
    .err_count (err_count),
    .seg0      (seg_d0),
    .seg3      (seg_d3)
);

// File: tb/pn10_frame_checker_test.sv
`timescale 1ns/1ps
module pn10_frame_checker_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_in = 1'b0;
    logic        clr_cnt = 1'b0;
    logic        locked;
    logic [15:0] err_count;
    logic [6:0]  seg_d0, seg_d1, seg_d2, seg_d3;

    always #10 clk = ~clk;   // 50 MHz

    pn10_frame_checker uut (
        .clk_bit   (clk),
        .rst_n     (rst_n),
        .ser_in    (ser_in),
        .clr_cnt   (clr_cnt),
        .locked    (locked),
        .err_count (err_count),
        .seg_d0    (seg_d0),
        .seg_d1    (seg_d1),
        .seg_d2    (seg_d2),
        .seg_d3    (seg_d3)
    );

    // R9 codes for 0..F, bit order g..a, active low.
    logic [6:0] seg_ref [16];
    initial begin
        seg_ref[0]  = 7'h40; seg_ref[1]  = 7'h79; seg_ref[2]  = 7'h24; seg_ref[3]  = 7'h30;
        seg_ref[4]  = 7'h19; seg_ref[5]  = 7'h12; seg_ref[6]  = 7'h02; seg_ref[7]  = 7'h78;
        seg_ref[8]  = 7'h00; seg_ref[9]  = 7'h10; seg_ref[10] = 7'h08; seg_ref[11] = 7'h03;
        seg_ref[12] = 7'h46; seg_ref[13] = 7'h21; seg_ref[14] = 7'h06; seg_ref[15] = 7'h0E;
    end

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Outputs recorded at the falling edge where the latest bit was driven.
    logic        obs_locked;
    logic [15:0] obs_cnt;
    logic [6:0]  obs_seg [4];

    // Sequence model (R2): x^10 + x^7 + 1 from all ones.
    logic [9:0] m_lfsr = 10'h3FF;
    int         m_pos = 0;
    int         exp_cnt = 0;

    function automatic logic model_bit();
        return m_lfsr[9];
    endfunction

    task automatic model_step();
        m_lfsr = {m_lfsr[8:0], m_lfsr[9] ^ m_lfsr[6]};
        m_pos = (m_pos + 1) % 1023;
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_raw(input logic b, input logic clr);
        @(negedge clk);
        obs_locked = locked;
        obs_cnt    = err_count;
        obs_seg[0] = seg_d0; obs_seg[1] = seg_d1;
        obs_seg[2] = seg_d2; obs_seg[3] = seg_d3;
        ser_in  = b;
        clr_cnt = clr;
        @(posedge clk);
    endtask

    // mode 0: clean sequence; mode 1: force each bit to zero (counts ones).
    task automatic send_pn(input int n, input int mode);
        for (int i = 0; i < n; i++) begin
            logic b;
            b = model_bit();
            if (mode == 1) begin
                if (b) exp_cnt++;
                b = 1'b0;
            end
            send_raw(b, 1'b0);
            model_step();
        end
    endtask

    task automatic check_segs(input string req, input int val);
        for (int k = 0; k < 4; k++)
            check(req, obs_seg[k], seg_ref[(val >> (4*k)) & 15]);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 locked in reset", locked, 0);
        rst_n = 1'b1;
        send_raw(1'b0, 1'b0);
        send_raw(1'b0, 1'b0);
        check("R1 locked", obs_locked, 0);
        check("R1 count", obs_cnt, 0);
        check_segs("R1 digits", 0);
    endtask

    task automatic t_prelock();
        for (int i = 0; i < 150; i++) send_raw(i[0], 1'b0);
        for (int i = 0; i < 60; i++) send_raw(1'b0, 1'b0);
        check("R3 no lock without run", obs_locked, 0);
        check("R4 no count before lock", obs_cnt, 0);
    endtask

    task automatic t_lock();
        for (int i = 0; i < 500; i++) model_step();
        while (m_pos != 10) send_pn(1, 0);
        // tenth one sampled; observe after edges t, t+1, t+2
        send_pn(1, 0);
        send_pn(1, 0);
        check("R3 locked one edge after", obs_locked, 0);
        send_pn(1, 0);
        check("R3 locked two edges after", obs_locked, 1);
        check("R4 count at lock", obs_cnt, 0);
    endtask

    task automatic t_clean();
        send_pn(2100, 0);
        check("R5 clean count", obs_cnt, 0);
        check("R5 lock kept", obs_locked, 1);
        check("R2 reference in step", obs_cnt, 0);
    endtask

    task automatic t_single();
        int base;
        base = obs_cnt;
        while (model_bit() != 1'b1) send_pn(1, 0);
        send_raw(1'b0, 1'b0);
        model_step();
        exp_cnt = base + 1;
        for (int i = 1; i <= 15; i++) begin
            send_pn(1, 0);
            if (i == 14) check("R6 not yet at edge 13", obs_cnt, base);
            if (i == 15) check("R6 plus one at edge 14", obs_cnt, base + 1);
        end
    endtask

    task automatic t_multi();
        int cnt0;
        cnt0 = exp_cnt;
        for (int i = 0; i < 700; i++) begin
            if ((i % 37) == 0 && model_bit()) begin
                send_raw(1'b0, 1'b0);
                model_step();
                exp_cnt++;
            end else begin
                send_pn(1, 0);
            end
        end
        send_pn(20, 0);
        check("R10 isolated flips", obs_cnt, exp_cnt);
        check("R10 flips seen", (exp_cnt > cnt0 + 5) ? 1 : 0, 1);
    endtask

    task automatic t_clear_zero();
        send_raw(model_bit(), 1'b1);
        model_step();
        send_pn(1, 0);
        check("R8 clear", obs_cnt, 0);
        check("R8 lock unchanged", obs_locked, 1);
        exp_cnt = 0;
        send_pn(800, 1);
        send_pn(20, 0);
        check("R10 zero stretch", obs_cnt, exp_cnt);
        check_segs("R9 digits", exp_cnt);
    endtask

    task automatic t_saturate();
        while (exp_cnt < 65535 + 40) send_pn(1, 1);
        send_pn(20, 0);
        check("R7 saturated", obs_cnt, 16'hFFFF);
        check_segs("R9 full digits", 16'hFFFF);
        send_raw(model_bit(), 1'b1);
        model_step();
        send_pn(1, 0);
        check("R8 clear from full", obs_cnt, 0);
    endtask

    initial begin
        t_reset();
        t_prelock();
        t_lock();
        t_clean();
        t_single();
        t_multi();
        t_clear_zero();
        t_saturate();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule